// File: doc/BRIEF.md
# Trap Entry Address Selector

This block chooses where instruction fetch resumes when the core takes a trap. It handles four kinds of trap: a synchronous exception, a non-maskable interrupt, an interrupt that enters through a shared handler, and an interrupt that is dispatched through a table of handler pointers in memory. It holds three base registers: a trap-vector base, a vector-table base and an alternate base for the shared interrupt handler. Software can read and write these registers through a small select-based access port.

When a trap request arrives, the block picks the winning kind and forms the target address. It also forms the cause value that the core writes to its cause register.

For a table-dispatched interrupt, the block first issues a single read of the table entry. It holds that read until the memory side answers, and then passes on the returned pointer as the target. The NMI entry is not stored. A single control bit, taken from bit 9 of the core's misc-control register, chooses whether the NMI follows the trap-vector base or the reset vector.

Top module: `trap_entry_sel`

## Requirements
- R1: An exception enters at the trap-vector base. The cause equals the exception code, zero-extended; the standard codes are 0 to 8 and 11.
- R2: Writes to the trap-vector base (select 0) clear bits 1:0. The read value shows the stored word.
- R3: An NMI reports cause 0xFFF. Its entry is the trap-vector base when `nmi_to_tvec_i` is 1, and `reset_vec_i` when it is 0.
- R4: A write to select 3 changes no register. A read of select 3 returns the NMI entry currently selected.
- R5: A shared-handler interrupt enters at the alternate base with bits 1:0 cleared when bit 0 of that register is 1, and at the trap-vector base otherwise. Writes to the alternate base (select 2) clear bit 1. An interrupt cause has bit XLEN-1 set and the interrupt ID in its low bits.
- R6: Writes to the vector-table base (select 1) clear every bit below the table alignment. The alignment is the larger of 64 bytes and 4·2^ceil(log2(NUM_SRC)) bytes, which is 256 bytes for the default 64 sources.
- R7: A table-dispatched interrupt raises `tbl_req_o` in the cycle after it is accepted. The request address is the table base plus 4·ID, and request and address are held until `tbl_rvalid_i`. In the following cycle, the entry is `tbl_rdata_i` with bit 0 cleared.
- R8: When several kinds are requested in the same cycle, NMI wins over exception, and exception wins over interrupt.
- R9: While a table read is outstanding (`busy_o` high), new trap requests are ignored and produce no entry.
- R10: A request accepted while idle that needs no table read produces a one-cycle `entry_valid_o` in the next cycle. After reset all base registers read 0, and no entry or table request is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_we_i | input | 1 | Register write strobe |
| csr_sel_i | input | 2 | Register select: 0 trap vector, 1 table base, 2 alternate base, 3 NMI entry |
| csr_wdata_i | input | XLEN | Write data |
| csr_rdata_o | output | XLEN | Read data for the selected register |
| nmi_to_tvec_i | input | 1 | Misc-control bit 9: NMI follows the trap vector when 1 |
| reset_vec_i | input | XLEN | Reset vector address |
| trap_nmi_i | input | 1 | NMI request |
| trap_exc_i | input | 1 | Exception request |
| trap_irq_i | input | 1 | Interrupt request |
| irq_vectored_i | input | 1 | Interrupt uses table dispatch |
| exc_code_i | input | EXC_W | Exception code |
| irq_id_i | input | log2(NUM_SRC) | Interrupt ID |
| tbl_req_o | output | 1 | Table read request |
| tbl_addr_o | output | XLEN | Table entry address |
| tbl_rvalid_i | input | 1 | Table read data valid |
| tbl_rdata_i | input | XLEN | Handler pointer read from the table |
| busy_o | output | 1 | Table read outstanding |
| entry_valid_o | output | 1 | Target address valid (one cycle) |
| entry_addr_o | output | XLEN | Next-fetch address |
| cause_o | output | XLEN | Cause value for the taken trap |

## Verification
Some properties are checked on every cycle:
- An NMI or exception accepted while idle yields an entry with the right cause in the next cycle.
- A pending table request and its address stay put until data returns.
- No entry appears while a read is outstanding.
- Entries never carry bit 0.
- A write to the NMI select leaves the stored bases unchanged.

Other behaviour is shown only by the bench's scenarios, against its behavioural model:
- the address masking of each register;
- the choice between the reset vector and the trap vector for the NMI;
- the choice between the alternate base and the trap vector for shared interrupts;
- the table address arithmetic at the highest ID;
- the priority among simultaneous requests.

// File: rtl/trap_sel_pkg.sv
package trap_sel_pkg;
  typedef enum logic [1:0] {
    CSR_TVEC  = 2'd0,
    CSR_TBASE = 2'd1,
    CSR_ALTB  = 2'd2,
    CSR_NMIV  = 2'd3
  } csr_sel_e;

  typedef enum logic [1:0] {
    K_EXC,
    K_NMI,
    K_IRQ_SHARED,
    K_IRQ_TABLE
  } trap_kind_e;

  typedef enum logic {
    ST_IDLE,
    ST_WAIT
  } fetch_st_e;

  localparam logic [11:0] NMI_CAUSE = 12'hFFF;
endpackage

// File: rtl/trap_csr_regs.sv
module trap_csr_regs
  import trap_sel_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int ALIGN_LSB = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  csr_sel_e        sel_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic            nmi_to_tvec_i,
  input  logic [XLEN-1:0] reset_vec_i,
  output logic [XLEN-1:0] rdata_o,
  output logic [XLEN-1:0] tvec_o,
  output logic [XLEN-1:0] tbase_o,
  output logic [XLEN-1:0] alt_base_o,
  output logic            alt_en_o,
  output logic [XLEN-1:0] nmi_entry_o
);
  localparam logic [XLEN-1:0] WORD_MASK  = ~XLEN'(3);
  localparam logic [XLEN-1:0] TBASE_MASK = ~((XLEN'(1) << ALIGN_LSB) - XLEN'(1));
  localparam logic [XLEN-1:0] ALT_MASK   = ~XLEN'(2);

  logic [XLEN-1:0] tvec_q, tbase_q, alt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tvec_q  <= '0;
      tbase_q <= '0;
      alt_q   <= '0;
    end else if (we_i) begin
      unique case (sel_i)
        CSR_TVEC:  tvec_q  <= wdata_i & WORD_MASK;
        CSR_TBASE: tbase_q <= wdata_i & TBASE_MASK;
        CSR_ALTB:  alt_q   <= wdata_i & ALT_MASK;
        default:   ;  // NMI entry is derived, writes dropped
      endcase
    end
  end

  assign nmi_entry_o = nmi_to_tvec_i ? tvec_q : reset_vec_i;
  assign tvec_o      = tvec_q;
  assign tbase_o     = tbase_q;
  assign alt_base_o  = alt_q & WORD_MASK;
  assign alt_en_o    = alt_q[0];

  always_comb begin
    unique case (sel_i)
      CSR_TVEC:  rdata_o = tvec_q;
      CSR_TBASE: rdata_o = tbase_q;
      CSR_ALTB:  rdata_o = alt_q;
      default:   rdata_o = nmi_entry_o;
    endcase
  end

  // R4: writes to the NMI select never disturb stored bases
  assert_nmi_write_ignored_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == CSR_NMIV) |=> ($stable(tvec_o) && $stable(tbase_o) && $stable(alt_base_o)
                                    && $stable(alt_en_o)));
endmodule

// File: rtl/trap_target_mux.sv
module trap_target_mux
  import trap_sel_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int ID_W  = 6,
  parameter int EXC_W = 4
) (
  input  logic             nmi_i,
  input  logic             exc_i,
  input  logic             irq_i,
  input  logic             irq_vectored_i,
  input  logic [EXC_W-1:0] exc_code_i,
  input  logic [ID_W-1:0]  irq_id_i,
  input  logic [XLEN-1:0]  tvec_i,
  input  logic [XLEN-1:0]  tbase_i,
  input  logic [XLEN-1:0]  alt_base_i,
  input  logic             alt_en_i,
  input  logic [XLEN-1:0]  nmi_entry_i,
  output logic             req_o,
  output trap_kind_e       kind_o,
  output logic [XLEN-1:0]  direct_addr_o,
  output logic [XLEN-1:0]  tbl_addr_o,
  output logic [XLEN-1:0]  cause_o
);
  logic [XLEN-1:0] irq_cause;
  assign irq_cause  = {1'b1, {(XLEN-1-ID_W){1'b0}}, irq_id_i};
  assign tbl_addr_o = tbase_i + (XLEN'(irq_id_i) << 2);
  assign req_o      = nmi_i | exc_i | irq_i;

  // fixed priority: NMI > exception > interrupt
  always_comb begin
    kind_o        = K_EXC;
    direct_addr_o = tvec_i;
    cause_o       = XLEN'(exc_code_i);
    if (nmi_i) begin
      kind_o        = K_NMI;
      direct_addr_o = nmi_entry_i;
      cause_o       = XLEN'(NMI_CAUSE);
    end else if (!exc_i && irq_i) begin
      cause_o = irq_cause;
      if (irq_vectored_i) begin
        kind_o        = K_IRQ_TABLE;
        direct_addr_o = '0;
      end else begin
        kind_o        = K_IRQ_SHARED;
        direct_addr_o = alt_en_i ? alt_base_i : tvec_i;
      end
    end
  end
endmodule

// File: rtl/trap_vec_fetch.sv
module trap_vec_fetch
  import trap_sel_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            use_table_i,
  input  logic [XLEN-1:0] direct_addr_i,
  input  logic [XLEN-1:0] tbl_addr_i,
  input  logic [XLEN-1:0] cause_i,
  input  logic            tbl_rvalid_i,
  input  logic [XLEN-1:0] tbl_rdata_i,
  output logic            busy_o,
  output logic            tbl_req_o,
  output logic [XLEN-1:0] tbl_addr_o,
  output logic            entry_valid_o,
  output logic [XLEN-1:0] entry_addr_o,
  output logic [XLEN-1:0] cause_o
);
  localparam logic [XLEN-1:0] PTR_MASK = ~XLEN'(1);

  fetch_st_e       state_q;
  logic            valid_q;
  logic [XLEN-1:0] addr_q, cause_q, taddr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      valid_q <= 1'b0;
      addr_q  <= '0;
      cause_q <= '0;
      taddr_q <= '0;
    end else begin
      valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          cause_q <= cause_i;
          if (use_table_i) begin
            state_q <= ST_WAIT;
            taddr_q <= tbl_addr_i;
          end else begin
            valid_q <= 1'b1;
            addr_q  <= direct_addr_i;
          end
        end
        default: if (tbl_rvalid_i) begin
          valid_q <= 1'b1;
          addr_q  <= tbl_rdata_i & PTR_MASK;
          state_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign busy_o        = (state_q == ST_WAIT);
  assign tbl_req_o     = busy_o;
  assign tbl_addr_o    = taddr_q;
  assign entry_valid_o = valid_q;
  assign entry_addr_o  = addr_q;
  assign cause_o       = cause_q;

  assert_tbl_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tbl_req_o && !tbl_rvalid_i) |=> (tbl_req_o && $stable(tbl_addr_o)));
  assert_entry_bit0_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_valid_o |-> (entry_addr_o[0] == 1'b0));
  assert_busy_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !tbl_rvalid_i) |=> !entry_valid_o);
  assert_no_req_with_entry_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_valid_o |-> !tbl_req_o);
endmodule

// File: rtl/trap_entry_sel.sv
module trap_entry_sel
  import trap_sel_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int NUM_SRC = 64,
  parameter int EXC_W   = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       csr_we_i,
  input  logic [1:0]                 csr_sel_i,
  input  logic [XLEN-1:0]            csr_wdata_i,
  output logic [XLEN-1:0]            csr_rdata_o,
  input  logic                       nmi_to_tvec_i,
  input  logic [XLEN-1:0]            reset_vec_i,
  input  logic                       trap_nmi_i,
  input  logic                       trap_exc_i,
  input  logic                       trap_irq_i,
  input  logic                       irq_vectored_i,
  input  logic [EXC_W-1:0]           exc_code_i,
  input  logic [$clog2(NUM_SRC)-1:0] irq_id_i,
  output logic                       tbl_req_o,
  output logic [XLEN-1:0]            tbl_addr_o,
  input  logic                       tbl_rvalid_i,
  input  logic [XLEN-1:0]            tbl_rdata_i,
  output logic                       busy_o,
  output logic                       entry_valid_o,
  output logic [XLEN-1:0]            entry_addr_o,
  output logic [XLEN-1:0]            cause_o
);
  localparam int ID_W      = $clog2(NUM_SRC);
  localparam int ALIGN_LSB = (ID_W + 2 > 6) ? ID_W + 2 : 6;

  logic [XLEN-1:0] tvec, tbase, alt_base, nmi_entry;
  logic            alt_en;
  logic            req;
  trap_kind_e      kind;
  logic [XLEN-1:0] direct_addr, tbl_addr, cause;

  trap_csr_regs #(.XLEN(XLEN), .ALIGN_LSB(ALIGN_LSB)) u_regs (
    .clk_i, .rst_ni,
    .we_i          (csr_we_i),
    .sel_i         (csr_sel_e'(csr_sel_i)),
    .wdata_i       (csr_wdata_i),
    .nmi_to_tvec_i (nmi_to_tvec_i),
    .reset_vec_i   (reset_vec_i),
    .rdata_o       (csr_rdata_o),
    .tvec_o        (tvec),
    .tbase_o       (tbase),
    .alt_base_o    (alt_base),
    .alt_en_o      (alt_en),
    .nmi_entry_o   (nmi_entry)
  );

  trap_target_mux #(.XLEN(XLEN), .ID_W(ID_W), .EXC_W(EXC_W)) u_mux (
    .nmi_i          (trap_nmi_i),
    .exc_i          (trap_exc_i),
    .irq_i          (trap_irq_i),
    .irq_vectored_i (irq_vectored_i),
    .exc_code_i     (exc_code_i),
    .irq_id_i       (irq_id_i),
    .tvec_i         (tvec),
    .tbase_i        (tbase),
    .alt_base_i     (alt_base),
    .alt_en_i       (alt_en),
    .nmi_entry_i    (nmi_entry),
    .req_o          (req),
    .kind_o         (kind),
    .direct_addr_o  (direct_addr),
    .tbl_addr_o     (tbl_addr),
    .cause_o        (cause)
  );

  trap_vec_fetch #(.XLEN(XLEN)) u_fetch (
    .clk_i, .rst_ni,
    .start_i       (req),
    .use_table_i   (kind == K_IRQ_TABLE),
    .direct_addr_i (direct_addr),
    .tbl_addr_i    (tbl_addr),
    .cause_i       (cause),
    .tbl_rvalid_i  (tbl_rvalid_i),
    .tbl_rdata_i   (tbl_rdata_i),
    .busy_o        (busy_o),
    .tbl_req_o     (tbl_req_o),
    .tbl_addr_o    (tbl_addr_o),
    .entry_valid_o (entry_valid_o),
    .entry_addr_o  (entry_addr_o),
    .cause_o       (cause_o)
  );

  assert_nmi_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && trap_nmi_i) |=> (entry_valid_o && cause_o == XLEN'(NMI_CAUSE)));
  assert_exc_over_irq_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && trap_exc_i && !trap_nmi_i) |=>
      (entry_valid_o && !tbl_req_o && cause_o == XLEN'($past(exc_code_i))));
  assert_tbl_word_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tbl_req_o |-> (tbl_addr_o[1:0] == 2'b00));
endmodule

// File: tb/tb_trap_entry_sel.sv
module tb_trap_entry_sel;
  localparam int XLEN    = 32;
  localparam int NUM_SRC = 64;
  localparam int EXC_W   = 4;
  localparam int ID_W    = $clog2(NUM_SRC);
  localparam logic [31:0] RST_VEC = 32'h8000_0000;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic csr_we_i = 0;
  logic [1:0] csr_sel_i = 0;
  logic [31:0] csr_wdata_i = 0, csr_rdata_o;
  logic nmi_to_tvec_i = 0;
  logic trap_nmi_i = 0, trap_exc_i = 0, trap_irq_i = 0, irq_vectored_i = 0;
  logic [EXC_W-1:0] exc_code_i = 0;
  logic [ID_W-1:0] irq_id_i = 0;
  logic tbl_req_o, tbl_rvalid_i = 0, busy_o, entry_valid_o;
  logic [31:0] tbl_addr_o, tbl_rdata_i = 0, entry_addr_o, cause_o;

  always #10 clk_i = ~clk_i;

  trap_entry_sel #(.XLEN(XLEN), .NUM_SRC(NUM_SRC), .EXC_W(EXC_W)) dut (
    .clk_i, .rst_ni, .csr_we_i, .csr_sel_i, .csr_wdata_i, .csr_rdata_o,
    .nmi_to_tvec_i, .reset_vec_i(RST_VEC), .trap_nmi_i, .trap_exc_i, .trap_irq_i,
    .irq_vectored_i, .exc_code_i, .irq_id_i, .tbl_req_o, .tbl_addr_o,
    .tbl_rvalid_i, .tbl_rdata_i, .busy_o, .entry_valid_o, .entry_addr_o, .cause_o
  );

  int checks = 0, fails = 0;
  bit run = 0, done = 0;
  string tag = "R10";

  task automatic chk(input bit ok, input string t, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp);
    end
  endtask

  // behavioural reference model
  int unsigned tbl_align;
  initial begin
    tbl_align = 64;
    while (tbl_align < 4 * NUM_SRC) tbl_align = tbl_align * 2;
  end

  logic [31:0] m_tv, m_tb, m_alt, m_addr, m_cause, m_taddr, m_pcause;
  bit m_valid, m_busy;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_tv <= 0; m_tb <= 0; m_alt <= 0; m_valid <= 0; m_busy <= 0;
      m_addr <= 0; m_cause <= 0; m_taddr <= 0; m_pcause <= 0;
    end else begin
      m_valid <= 0;
      if (csr_we_i) begin
        if (csr_sel_i == 0) m_tv <= csr_wdata_i & ~32'h3;
        if (csr_sel_i == 1) m_tb <= csr_wdata_i & ~(tbl_align - 1);
        if (csr_sel_i == 2) m_alt <= csr_wdata_i & ~32'h2;
      end
      if (m_busy) begin
        if (tbl_rvalid_i) begin
          m_valid <= 1; m_busy <= 0;
          m_addr <= tbl_rdata_i & ~32'h1; m_cause <= m_pcause;
        end
      end else if (trap_nmi_i) begin
        m_valid <= 1; m_cause <= 32'hFFF;
        m_addr <= nmi_to_tvec_i ? m_tv : RST_VEC;
      end else if (trap_exc_i) begin
        m_valid <= 1; m_cause <= 32'(exc_code_i); m_addr <= m_tv;
      end else if (trap_irq_i) begin
        if (irq_vectored_i) begin
          m_busy <= 1; m_taddr <= m_tb + 4 * 32'(irq_id_i);
          m_pcause <= 32'h8000_0000 | 32'(irq_id_i);
        end else begin
          m_valid <= 1; m_cause <= 32'h8000_0000 | 32'(irq_id_i);
          m_addr <= m_alt[0] ? (m_alt & ~32'h3) : m_tv;
        end
      end
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && run && !done) begin
      chk(entry_valid_o === m_valid, {tag, " entry_valid"}, 32'(entry_valid_o), 32'(m_valid));
      if (m_valid) begin
        chk(entry_addr_o === m_addr, {tag, " entry_addr"}, entry_addr_o, m_addr);
        chk(cause_o === m_cause, {tag, " cause"}, cause_o, m_cause);
      end
      chk(tbl_req_o === m_busy, {tag, " tbl_req"}, 32'(tbl_req_o), 32'(m_busy));
      if (m_busy) chk(tbl_addr_o === m_taddr, {tag, " tbl_addr"}, tbl_addr_o, m_taddr);
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    csr_we_i = 1; csr_sel_i = sel; csr_wdata_i = d;
    @(negedge clk_i);
    csr_we_i = 0;
  endtask

  task automatic rd(input logic [1:0] sel, input logic [31:0] exp, input string t);
    csr_sel_i = sel;
    #1;
    chk(csr_rdata_o === exp, t, csr_rdata_o, exp);
  endtask

  task automatic trap(input bit n, input bit e, input bit i, input bit v,
                      input logic [EXC_W-1:0] c, input logic [ID_W-1:0] id);
    trap_nmi_i = n; trap_exc_i = e; trap_irq_i = i; irq_vectored_i = v;
    exc_code_i = c; irq_id_i = id;
    @(negedge clk_i);
    trap_nmi_i = 0; trap_exc_i = 0; trap_irq_i = 0; irq_vectored_i = 0;
  endtask

  task automatic respond(input logic [31:0] d);
    tbl_rvalid_i = 1; tbl_rdata_i = d;
    @(negedge clk_i);
    tbl_rvalid_i = 0;
  endtask

  task automatic entry_is(input logic [31:0] a, input logic [31:0] c, input string t);
    chk(entry_valid_o === 1'b1, {t, " valid"}, 32'(entry_valid_o), 32'd1);
    chk(entry_addr_o === a, {t, " addr"}, entry_addr_o, a);
    chk(cause_o === c, {t, " cause"}, cause_o, c);
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R10 actual=%h expected=%h", 32'd0, 32'd1);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1; run = 1;
    // R10: reset state
    chk(entry_valid_o === 1'b0, "R10 reset entry_valid", 32'(entry_valid_o), 0);
    chk(tbl_req_o === 1'b0, "R10 reset tbl_req", 32'(tbl_req_o), 0);
    rd(0, 0, "R10 reset tvec"); rd(1, 0, "R10 reset tbase"); rd(2, 0, "R10 reset alt");
    @(negedge clk_i);

    tag = "R2"; wr(0, 32'h1000_0103); rd(0, 32'h1000_0100, "R2 tvec mask");

    tag = "R1";
    trap(0, 1, 0, 0, 4'd2, 0); entry_is(32'h1000_0100, 32'd2, "R1 exc code 2");
    trap(0, 1, 0, 0, 4'd11, 0); entry_is(32'h1000_0100, 32'd11, "R1 exc code 11");

    tag = "R3";
    nmi_to_tvec_i = 1; trap(1, 0, 0, 0, 0, 0); entry_is(32'h1000_0100, 32'hFFF, "R3 nmi tvec");
    nmi_to_tvec_i = 0; trap(1, 0, 0, 0, 0, 0); entry_is(RST_VEC, 32'hFFF, "R3 nmi reset vec");

    tag = "R4";
    wr(3, 32'h1234_5678); rd(3, RST_VEC, "R4 nmi read reset");
    nmi_to_tvec_i = 1; rd(3, 32'h1000_0100, "R4 nmi read tvec");
    rd(0, 32'h1000_0100, "R4 tvec untouched"); rd(1, 0, "R4 tbase untouched");
    rd(2, 0, "R4 alt untouched");
    @(negedge clk_i);

    tag = "R5";
    trap(0, 0, 1, 0, 0, 6'd9); entry_is(32'h1000_0100, 32'h8000_0009, "R5 shared via tvec");
    wr(2, 32'h2000_0043); rd(2, 32'h2000_0041, "R5 alt mask");
    @(negedge clk_i);
    trap(0, 0, 1, 0, 0, 6'd63); entry_is(32'h2000_0040, 32'h8000_003F, "R5 shared via alt");

    tag = "R6"; wr(1, 32'h3000_12FF); rd(1, 32'h3000_1200, "R6 tbase align");
    @(negedge clk_i);

    tag = "R7";
    trap(0, 0, 1, 1, 0, 6'd5);
    chk(tbl_req_o === 1'b1, "R7 tbl_req", 32'(tbl_req_o), 1);
    chk(tbl_addr_o === 32'h3000_1214, "R7 tbl_addr", tbl_addr_o, 32'h3000_1214);
    tag = "R9"; trap(0, 1, 0, 0, 4'd3, 0);
    chk(entry_valid_o === 1'b0, "R9 ignored while busy", 32'(entry_valid_o), 0);
    repeat (2) @(negedge clk_i);
    tag = "R7"; respond(32'h4000_0081);
    entry_is(32'h4000_0080, 32'h8000_0005, "R7 vectored entry");
    @(negedge clk_i);
    trap(0, 0, 1, 1, 0, 6'd63);
    chk(tbl_addr_o === 32'h3000_12FC, "R7 tbl_addr top id", tbl_addr_o, 32'h3000_12FC);
    respond(32'h4000_0200); entry_is(32'h4000_0200, 32'h8000_003F, "R7 top id entry");

    tag = "R8";
    trap(1, 1, 1, 0, 4'd3, 6'd4); entry_is(32'h1000_0100, 32'hFFF, "R8 nmi wins");
    trap(0, 1, 1, 1, 4'd5, 6'd4); entry_is(32'h1000_0100, 32'd5, "R8 exc wins");
    chk(tbl_req_o === 1'b0, "R8 no table read", 32'(tbl_req_o), 0);

    repeat (3) @(negedge clk_i);
    finish_run();
  end
endmodule